// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is an up-counter timer that turns two compare settings into a pulse-width-modulated waveform. The period setting fixes how many count ticks make up one cycle. The width setting fixes how many of those ticks the output stays active. Software writes both settings into holding registers, and the block reads them at safe points only. The working copies that the counter compares against are refreshed when the enable is first raised, and after that only when the period match clears the counter. Because of this, a setting that changes in the middle of a cycle never produces a cut-short or stretched cycle.

Raising the enable puts the counter at all-ones. The next count tick moves it to zero, and counting starts from there. Each time the counter clears after matching the period, the block raises a one-clock period interrupt pulse and flips a square-wave period output. A second one-clock pulse marks the tick on which the counter reaches the width value. Dropping the enable freezes the counter and forces both waveform outputs low. The counter advances only on clocks where the count-tick input is high.

Top module: `pwm_timer`

## Requirements
- R1: While reset is high, and on the first clock after it, `count` reads all-ones and `pwm_out`, `period_out`, `irq_period` and `irq_width` are all 0.
- R2: On the first clock where `run_en` is high after it was low, the counter loads all-ones and both working settings copy the holding values. The next tick clears the counter to 0 without any period pulse.
- R3: While running, the counter changes only on clocks where `tick` is 1. It counts 0, 1, …, P and then returns to 0, so one cycle lasts P+1 ticks, where P is the working period setting.
- R4: `pwm_out` goes high when the counter clears to 0 and goes low when the counter reaches the working width W. The output is therefore high for W ticks of each cycle.
- R5: A width of 0 keeps `pwm_out` low for the whole cycle. A width greater than P keeps `pwm_out` high for the whole cycle.
- R6: Writes made while running, including a write in the same clock as a period match, reach the working settings only at a later period-match clear.
- R7: When the counter clears after matching P, `irq_period` is 1 for the clock that follows and `period_out` inverts.
- R8: `irq_width` is 1 for the clock after the counter takes a value equal to the working width. This includes value 0 at a clear when W is 0.
- R9: While `run_en` is 0, the counter holds its value and `pwm_out`, `period_out` and both pulses are 0. Raising `run_en` again restarts the sequence described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer enable bit |
| tick | input | 1 | Count-clock enable; the counter moves only when high |
| wr_per | input | 1 | Write strobe for the period holding register |
| wr_wid | input | 1 | Write strobe for the width holding register |
| wr_data | input | CW | Value written by either strobe |
| count | output | CW | Current counter value |
| pwm_out | output | 1 | PWM waveform |
| period_out | output | 1 | Output that toggles at each period match |
| irq_period | output | 1 | One-clock period-match pulse |
| irq_width | output | 1 | One-clock width-match pulse |

## Verification
The hardest case to reach is a holding-register write that lands on exactly the clock where the counter matches the period and clears. In that case the buffers must take the old holding value and not the new one. To force this case, the stimulus keeps ticks continuous, watches the reference model's counter, and raises the write strobe on the clock where the counter equals the working period. It also stops the timer partway through a cycle and re-enables it, to exercise the restart from all-ones together with the fresh buffer load.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_ARM,
        STEP_HOLD,
        STEP_START,
        STEP_WRAP,
        STEP_INC
    } step_e;

    typedef struct packed {
        logic pwm;
        logic tgl;
        logic irq_p;
        logic irq_w;
    } wave_s;

    function automatic logic is_clear(step_e s);
        return (s == STEP_START) || (s == STEP_WRAP);
    endfunction

endpackage

// File: rtl/ptm_regs.sv
module ptm_regs #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_per,
    input  logic          wr_wid,
    input  logic [CW-1:0] wr_data,
    input  logic          load,
    output logic [CW-1:0] per_hold,
    output logic [CW-1:0] wid_hold,
    output logic [CW-1:0] per_buf,
    output logic [CW-1:0] wid_buf
);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_hold <= '0;
            wid_hold <= '0;
            per_buf  <= '0;
            wid_buf  <= '0;
        end else begin
            if (wr_per) per_hold <= wr_data;
            if (wr_wid) wid_hold <= wr_data;
            if (load) begin
                per_buf <= per_hold;
                wid_buf <= wid_hold;
            end
        end
    end

endmodule

// File: rtl/ptm_count.sv
module ptm_count
    import ptm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          tick,
    input  logic [CW-1:0] per_buf,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] nxt,
    output step_e         step
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic running;
    logic first;

    always_comb begin
        if (!run_en)            step = STEP_IDLE;
        else if (!running)      step = STEP_ARM;
        else if (!tick)         step = STEP_HOLD;
        else if (first)         step = STEP_START;
        else if (cnt == per_buf) step = STEP_WRAP;
        else                    step = STEP_INC;
    end

    always_comb begin
        case (step)
            STEP_ARM:               nxt = '1;
            STEP_START, STEP_WRAP:  nxt = '0;
            STEP_INC:               nxt = cnt + ONE;
            default:                nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '1;
            running <= 1'b0;
            first   <= 1'b0;
        end else begin
            cnt     <= nxt;
            running <= run_en;
            if (step == STEP_ARM)        first <= 1'b1;
            else if (step == STEP_START) first <= 1'b0;
        end
    end

endmodule

// File: rtl/ptm_wave.sv
module ptm_wave
    import ptm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  step_e         step,
    input  logic [CW-1:0] nxt,
    input  logic [CW-1:0] wid_eff,
    output wave_s         wave
);

    wave_s wave_d;
    logic  hit;

    assign hit = (nxt == wid_eff);

    always_comb begin
        wave_d       = wave;
        wave_d.irq_p = 1'b0;
        wave_d.irq_w = 1'b0;
        if (step == STEP_IDLE) begin
            wave_d.pwm = 1'b0;
            wave_d.tgl = 1'b0;
        end else if (is_clear(step)) begin
            wave_d.pwm   = !hit;
            wave_d.irq_w = hit;
            if (step == STEP_WRAP) begin
                wave_d.irq_p = 1'b1;
                wave_d.tgl   = !wave.tgl;
            end
        end else if (step == STEP_INC && hit) begin
            wave_d.pwm   = 1'b0;
            wave_d.irq_w = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wave <= '0;
        else     wave <= wave_d;
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import ptm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          tick,
    input  logic          wr_per,
    input  logic          wr_wid,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count,
    output logic          pwm_out,
    output logic          period_out,
    output logic          irq_period,
    output logic          irq_width
);

    logic [CW-1:0] per_hold, wid_hold, per_buf, wid_buf;
    logic [CW-1:0] cnt, nxt, wid_eff;
    step_e         step;
    wave_s         wave;
    logic          load;

    assign load    = (step == STEP_ARM) || (step == STEP_WRAP);
    assign wid_eff = (step == STEP_WRAP) ? wid_hold : wid_buf;

    ptm_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_per(wr_per), .wr_wid(wr_wid),
        .wr_data(wr_data), .load(load), .per_hold(per_hold),
        .wid_hold(wid_hold), .per_buf(per_buf), .wid_buf(wid_buf)
    );

    ptm_count #(.CW(CW)) u_count (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
        .per_buf(per_buf), .cnt(cnt), .nxt(nxt), .step(step)
    );

    ptm_wave #(.CW(CW)) u_wave (
        .clk(clk), .rst(rst), .step(step), .nxt(nxt),
        .wid_eff(wid_eff), .wave(wave)
    );

    assign count      = cnt;
    assign pwm_out    = wave.pwm;
    assign period_out = wave.tgl;
    assign irq_period = wave.irq_p;
    assign irq_width  = wave.irq_w;

endmodule

// File: rtl/ptm_check.sv
module ptm_check
    import ptm_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          run_en,
    input step_e         step,
    input logic [CW-1:0] per_buf,
    input logic [CW-1:0] count,
    input logic          pwm_out,
    input logic          period_out,
    input logic          irq_period,
    input logic          irq_width
);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(count));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!pwm_out && !period_out && !irq_period && !irq_width));

    assert_period_clear_R7: assert property (@(posedge clk) disable iff (rst)
        irq_period |-> (count == '0));

    assert_buf_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (step != STEP_WRAP && step != STEP_ARM) |=> $stable(per_buf));

    assert_width_low_R8: assert property (@(posedge clk) disable iff (rst)
        irq_width |-> !pwm_out);

endmodule

bind pwm_timer ptm_check #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .step(step), .per_buf(per_buf),
    .count(count), .pwm_out(pwm_out), .period_out(period_out),
    .irq_period(irq_period), .irq_width(irq_width)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;

    localparam int CW = 16;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic          tick = 1'b0;
    logic          wr_per = 1'b0;
    logic          wr_wid = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] count;
    logic          pwm_out, period_out, irq_period, irq_width;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = MAXV, m_ph = 0, m_wh = 0, m_pb = 0, m_wb = 0;
    bit m_run = 0, m_first = 0, m_pwm = 0, m_tgl = 0, m_ip = 0, m_iw = 0;

    always #2.5 clk = ~clk;

    pwm_timer #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
        .wr_per(wr_per), .wr_wid(wr_wid), .wr_data(wr_data),
        .count(count), .pwm_out(pwm_out), .period_out(period_out),
        .irq_period(irq_period), .irq_width(irq_width)
    );

    always @(posedge clk) begin
        int nph, nwh;
        if (rst) begin
            m_cnt = MAXV; m_run = 0; m_first = 0; m_ph = 0; m_wh = 0;
            m_pb = 0; m_wb = 0; m_pwm = 0; m_tgl = 0; m_ip = 0; m_iw = 0;
        end else begin
            nph = wr_per ? int'(wr_data) : m_ph;
            nwh = wr_wid ? int'(wr_data) : m_wh;
            m_ip = 0;
            m_iw = 0;
            if (!run_en) begin
                m_run = 0; m_pwm = 0; m_tgl = 0;
            end else if (!m_run) begin
                m_run = 1; m_first = 1; m_cnt = MAXV; m_pb = m_ph; m_wb = m_wh;
            end else if (tick) begin
                if (m_first) begin
                    m_first = 0; m_cnt = 0;
                    m_pwm = (m_wb != 0); m_iw = (m_wb == 0);
                end else if (m_cnt == m_pb) begin
                    m_cnt = 0; m_pb = m_ph; m_wb = m_wh;
                    m_pwm = (m_wb != 0); m_iw = (m_wb == 0);
                    m_ip = 1; m_tgl = !m_tgl;
                end else begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == m_wb) begin m_iw = 1; m_pwm = 0; end
                end
            end
            m_ph = nph;
            m_wh = nwh;
        end
    end

    task automatic cmp(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cmp(tag == "R1" ? "R1" : "R3", "count", int'(count), m_cnt);
        cmp(tag == "R5" ? "R5" : "R4", "pwm_out", int'(pwm_out), int'(m_pwm));
        cmp("R7", "period_out", int'(period_out), int'(m_tgl));
        cmp("R7", "irq_period", int'(irq_period), int'(m_ip));
        cmp("R8", "irq_width", int'(irq_width), int'(m_iw));
    end

    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_per = 1'b0;
            wr_wid = 1'b0;
            tick = (mode == 0) ? 1'b1 : ((i % 3) == 0);
        end
    endtask

    task automatic wr(bit sel_per, int val);
        @(negedge clk);
        tick = 1'b1;
        wr_per = sel_per;
        wr_wid = !sel_per;
        wr_data = CW'(val);
        @(negedge clk);
        wr_per = 1'b0;
        wr_wid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run(3, 0);
        // R2: settings then enable, restart from all-ones
        tag = "R2";
        wr(1, 9);
        wr(0, 3);
        @(negedge clk); run_en = 1'b1; tick = 1'b0;
        run(40, 0);
        // R3: sparse ticks
        tag = "R3";
        run(90, 1);
        // R6: write landing on the period-match clock
        tag = "R6";
        @(negedge clk); tick = 1'b1;
        while (!(m_cnt == m_pb && !m_first)) @(negedge clk);
        wr_per = 1'b1; wr_data = CW'(5);
        @(negedge clk); wr_per = 1'b0;
        run(30, 0);
        wr(0, 2);
        run(30, 0);
        // R5: zero width, then width above period
        tag = "R5";
        wr(0, 0);
        run(30, 0);
        wr(0, 20);
        run(30, 0);
        // period 0 corner with width 1
        tag = "R4";
        wr(1, 0);
        wr(0, 1);
        run(12, 0);
        wr(1, 6);
        wr(0, 4);
        run(30, 1);
        // R9: stop mid-cycle, ticks continue, then restart
        tag = "R9";
        run(4, 0);
        @(negedge clk); run_en = 1'b0;
        run(10, 0);
        wr(1, 3);
        @(negedge clk); run_en = 1'b1;
        run(30, 0);
        tag = "R7";
        run(40, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule